// File: doc/BRIEF.md
# Zero-wait pipelined burst SRAM

This block is a synthesizable model of a synchronous static RAM that keeps its data bus fully busy. Reads and writes can be issued on consecutive clock edges in any order, with no idle cycles needed at a change of direction. Every control input is registered on the rising clock edge. Read data leaves through an output register. Write data is taken from the input bus two enabled edges after its address, so a write placed directly behind a read never competes with that read for the bus.

A small state machine tracks what the last issued operation was. The states are `ST_DESEL` (deselected), `ST_READ` (read burst), `ST_WRITE` (write burst) and `ST_SLEEP` (inputs ignored). With `adv` low, every enabled edge is a load. It goes to `ST_READ` or `ST_WRITE` when the chip is selected and to `ST_DESEL` when it is not. With `adv` high, `ST_READ` and `ST_WRITE` loop on themselves and step a 2-bit burst counter. `ST_DESEL` and `ST_SLEEP` move to, or stay in, `ST_DESEL`. While the delayed sleep flag is set, every enabled edge moves to `ST_SLEEP`. A low clock-enable pin (`cke_n` high) freezes the state machine and every pipeline register. The array is a register array of 2^`ADDR_W` words. Each word is made of `LANES` byte lanes of `LANE_W` bits, and a 9-bit lane carries its parity bit as ordinary data.

Top module: `zbt_sram`

## Requirements
- R1: A read sampled on enabled edge k drives `dout` with `dout_en` high after enabled edge k+1 and until edge k+2. After edge k itself `dout_en` reflects the previous command, not this read.
- R2: Reads and writes may alternate on consecutive enabled edges with no idle cycle. Each read still returns the word that matches its own address.
- R3: A write's data is captured from `din` on the second enabled edge after its command. A read whose array access meets that pending write at the same address returns the new data in the lanes the write enables and the old data in the other lanes.
- R4: On a write (`wr_n` low), lane i (bits 9i+8..9i for the default width) is written only when `bw_n[i]` is low. With `bw_n` all ones the write is aborted and no memory changes.
- R5: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination on a load edge is a deselect: nothing is written and `dout_en` stays low.
- R6: While `cke_n` is high, all synchronous inputs are ignored, and the state, pipeline and output registers hold their values.
- R7: With `adv` high, a read or write burst continues with the chip enables and `wr_n` ignored. The low 2 address bits of step i are base+i mod 4 when `interleave`=0 and base XOR i when `interleave`=1. The upper bits stay fixed.
- R8: `adv` high while deselected continues the deselect: no read, no write.
- R9: `sleep` sampled high on enabled edge k makes inputs ignored from edge k+2 on, while commands on k and k+1 still execute. After `sleep` returns low, inputs are sampled again from the second edge on. `dout_en` is low while `sleep` or its delayed copy is high.
- R10: `dout_en` follows `oe_n` without waiting for a clock and is low whenever `oe_n` is high, and after write or deselect commands.
- R11: After reset `dout_en` is low, the state is `ST_DESEL` and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address, loaded when adv is low |
| wr_n | input | 1 | Low selects write on a load edge |
| bw_n | input | LANES | Active-low byte lane write strobes |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | High continues the burst, low loads a new command |
| cke_n | input | 1 | High freezes the whole block |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, takes effect after two edges |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | LANE_W*LANES | Write data bus |
| dout | output | LANE_W*LANES | Registered read data |
| dout_en | output | 1 | Tri-state enable for dout |

## Verification
The bench places a read, a write and a read to the written address on three consecutive edges. A design without the bypass path would return stale array data for the last read, and one with an extra pipeline register would show read data one cycle late or collide with the write slot. Partial strobes against a pending write expose lane merging that is swapped or is all-or-nothing. Bursts are started at unaligned addresses in both orders so that a counter which carries into the upper bits, or which applies the wrong order, reads the wrong word. Freeze, sleep entry and exit edges, continue-deselect and the unselected enable combinations are each driven with a write pattern, so any leak of an input through those paths changes memory that the bench then reads back.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    // Operation carried down the pipeline
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } state_e;

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
    import zbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sleep,
    input  logic adv,
    input  logic selected,
    input  logic wr_n,
    output op_e  op_o,
    output logic load_o,
    output logic step_o,
    output logic asleep_o
);

    state_e state_q, state_d;
    logic   sl1_q, sl2_q;

    // Sleep request delay line, runs on every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl1_q <= 1'b0;
            sl2_q <= 1'b0;
        end else begin
            sl1_q <= sleep;
            sl2_q <= sl1_q;
        end
    end

    assign asleep_o = sl2_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    // Next state and issued command
    always_comb begin
        state_d = state_q;
        op_o    = OP_NOP;
        load_o  = 1'b0;
        step_o  = 1'b0;
        if (sl2_q) begin
            state_d = ST_SLEEP;
        end else if (!adv) begin
            load_o = 1'b1;
            if (!selected) begin
                state_d = ST_DESEL;
            end else if (!wr_n) begin
                state_d = ST_WRITE;
                op_o    = OP_WR;
            end else begin
                state_d = ST_READ;
                op_o    = OP_RD;
            end
        end else begin
            unique case (state_q)
                ST_READ: begin
                    op_o   = OP_RD;
                    step_o = 1'b1;
                end
                ST_WRITE: begin
                    op_o   = OP_WR;
                    step_o = 1'b1;
                end
                ST_DESEL, ST_SLEEP: state_d = ST_DESEL;
                default:            state_d = ST_DESEL;
            endcase
        end
    end

    // R8
    cont_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sl2_q && adv && state_q == ST_DESEL) |=> (state_q == ST_DESEL));

    // R9
    sleep_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sl2_q) |=> (state_q == ST_SLEEP));

    // R6
    freeze_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

endmodule

// File: rtl/zbt_burst.sv
`timescale 1ns/1ps
module zbt_burst #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] issue_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q, cnt_nxt, lo;

    assign cnt_nxt = cnt_q + 1'b1;

    always_comb begin
        if (interleave) lo = base_q[BURST_W-1:0] ^ cnt_nxt;
        else            lo = base_q[BURST_W-1:0] + cnt_nxt;
        issue_addr = load ? addr_in : {base_q[ADDR_W-1:BURST_W], lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R7
    burst_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !load) |=> (base_q == $past(base_q)));

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANE_W*LANES-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANE_W*LANES-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (lane_we[g]) begin
                bank[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANE_W  = 9,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv,
    input  logic                    cke_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    interleave,
    input  logic [LANE_W*LANES-1:0] din,
    output logic [LANE_W*LANES-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANE_W * LANES;

    logic              en, selected, asleep, load, step;
    op_e               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_bw_n, s2_bw_n, lane_we;
    logic              rd_v, hit;
    logic [DATA_W-1:0] dout_q, arr_rdata, fwd_data;

    assign en       = ~cke_n;
    assign selected = ~cs1_n & cs2 & ~cs3_n;

    zbt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sleep    (sleep),
        .adv      (adv),
        .selected (selected),
        .wr_n     (wr_n),
        .op_o     (iss_op),
        .load_o   (load),
        .step_o   (step),
        .asleep_o (asleep)
    );

    zbt_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .load       (load),
        .step       (step),
        .interleave (interleave),
        .addr_in    (addr),
        .issue_addr (iss_addr)
    );

    // Two-stage late-write pipeline plus output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NOP;
            s2_op   <= OP_NOP;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_bw_n <= '1;
            s2_bw_n <= '1;
            rd_v    <= 1'b0;
            dout_q  <= '0;
        end else if (en) begin
            s1_op   <= iss_op;
            s1_addr <= iss_addr;
            s1_bw_n <= bw_n;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
            rd_v    <= (s1_op == OP_RD);
            if (s1_op == OP_RD) dout_q <= fwd_data;
        end
    end

    // Commit of the oldest write, data taken from the bus now
    assign lane_we = (en && s2_op == OP_WR) ? ~s2_bw_n : '0;
    assign hit     = (s2_op == OP_WR) && (s2_addr == s1_addr);

    // Per-lane bypass of the write committing on this edge
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_data[g*LANE_W +: LANE_W] = (hit && !s2_bw_n[g]) ?
            din[g*LANE_W +: LANE_W] : arr_rdata[g*LANE_W +: LANE_W];
    end

    zbt_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .waddr   (s2_addr),
        .wdata   (din),
        .raddr   (s1_addr),
        .rdata   (arr_rdata)
    );

    assign dout    = dout_q;
    assign dout_en = rd_v & ~oe_n & ~sleep & ~asleep;

    // R10
    oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R5
    desel_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !asleep && !adv && !selected) |=> (s1_op == OP_NOP));

    // R6
    freeze_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout_q) && $stable(rd_v)));

    // R2
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s1_op == OP_WR) |=> !rd_v);

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int DW = 36;
    localparam int K_DES = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          wr_n, cs1_n, cs2, cs3_n, adv, cke_n, oe_n, sleep, interleave;
    logic [NL-1:0] bw_n;
    logic [DW-1:0] din, dout;
    logic          dout_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [64];

    always #5 clk = ~clk;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n), .bw_n(bw_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv(adv), .cke_n(cke_n),
        .oe_n(oe_n), .sleep(sleep), .interleave(interleave), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Lane i takes the new value when its strobe is low
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NL-1:0] strobes_n);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NL; i++)
            if (!strobes_n[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic cmd(input int kind, input logic [AW-1:0] a, input logic [NL-1:0] bw, input logic av);
        addr = a;
        bw_n = bw;
        adv  = av;
        cs1_n = (kind == K_DES);
        cs2   = 1'b1;
        cs3_n = 1'b0;
        wr_n  = (kind != K_WR);
    endtask

    task automatic write_one(input logic [AW-1:0] a, input logic [NL-1:0] bw, input logic [DW-1:0] data);
        cmd(K_WR, a, bw, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        din = data;
        tick();
        ref_mem[a] = merge(ref_mem[a], data, bw);
    endtask

    task automatic read_one(input logic [AW-1:0] a, input string req);
        cmd(K_RD, a, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        chk_bit(req, dout_en, 1'b1);
        chk(req, dout, ref_mem[a]);
    endtask

    task automatic t_reset();
        chk_bit("R11 reset dout_en", dout_en, 1'b0);
        read_one(6'd0, "R11 reset contents");
    endtask

    task automatic t_latency();
        write_one(6'd3, 4'b0000, 36'h123456789);
        cmd(K_RD, 6'd3, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        chk_bit("R1 not yet driven", dout_en, 1'b0);
        tick();
        chk_bit("R1 driven", dout_en, 1'b1);
        chk("R1 data", dout, 36'h123456789);
        tick();
        chk_bit("R10 deselect hi-z", dout_en, 1'b0);
    endtask

    task automatic t_bytes();
        write_one(6'd7, 4'b0000, 36'h111111111);
        write_one(6'd7, 4'b1010, 36'hFEDCBA987);
        read_one(6'd7, "R4 lane strobes");
        write_one(6'd7, 4'b1111, 36'h000000000);
        read_one(6'd7, "R4 write abort");
    endtask

    task automatic t_back_to_back();
        logic [DW-1:0] exp;
        cmd(K_RD, 6'd3, '1, 1'b0);
        tick();
        cmd(K_WR, 6'd9, 4'b0000, 1'b0);
        tick();
        chk_bit("R2 read before write", dout_en, 1'b1);
        chk("R2 read before write", dout, ref_mem[3]);
        cmd(K_RD, 6'd9, '1, 1'b0);
        din = 36'h0A5A5A5A5;
        tick();
        chk_bit("R10 write slot hi-z", dout_en, 1'b0);
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        ref_mem[9] = 36'h0A5A5A5A5;
        chk_bit("R2 read after write", dout_en, 1'b1);
        chk("R3 full forward", dout, 36'h0A5A5A5A5);
        write_one(6'd12, 4'b0000, 36'h5A5A5A5A5);
        cmd(K_WR, 6'd12, 4'b0101, 1'b0);
        tick();
        cmd(K_RD, 6'd12, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        din = 36'hC3C3C3C3C;
        tick();
        exp = merge(ref_mem[12], 36'hC3C3C3C3C, 4'b0101);
        ref_mem[12] = exp;
        chk("R3 lane merge forward", dout, exp);
        tick();
        read_one(6'd12, "R3 merged word stored");
    endtask

    task automatic t_chip_select();
        write_one(6'd20, 4'b0000, 36'h0CAFE0000);
        for (int c = 0; c < 3; c++) begin
            cmd(K_WR, 6'd20, 4'b0000, 1'b0);
            if (c == 0) cs1_n = 1'b1;
            if (c == 1) cs2 = 1'b0;
            if (c == 2) cs3_n = 1'b1;
            tick();
            cmd(K_DES, '0, '1, 1'b0);
            tick();
            din = 36'hBADBADBAD;
            tick();
            chk_bit("R5 deselect no drive", dout_en, 1'b0);
        end
        cmd(K_RD, 6'd20, '1, 1'b0);
        cs2 = 1'b0;
        tick();
        tick();
        chk_bit("R5 unselected read", dout_en, 1'b0);
        read_one(6'd20, "R5 unselected writes ignored");
    endtask

    task automatic t_freeze();
        cmd(K_RD, 6'd3, '1, 1'b0);
        tick();
        cke_n = 1'b1;
        cmd(K_WR, 6'd3, 4'b0000, 1'b0);
        din = 36'hEEEEEEEEE;
        tick();
        tick();
        chk_bit("R6 frozen before output", dout_en, 1'b0);
        cke_n = 1'b0;
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        chk_bit("R6 resumed", dout_en, 1'b1);
        chk("R6 resumed data", dout, ref_mem[3]);
        cke_n = 1'b1;
        tick();
        tick();
        chk_bit("R6 output held", dout_en, 1'b1);
        chk("R6 output held", dout, ref_mem[3]);
        cke_n = 1'b0;
        tick();
        chk_bit("R6 released", dout_en, 1'b0);
        read_one(6'd3, "R6 frozen write ignored");
    endtask

    task automatic burst_read(input logic [AW-1:0] base, input logic ilv, input string req);
        logic [AW-1:0] a;
        logic [1:0] lo;
        interleave = ilv;
        cmd(K_RD, base, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            if (i == 3) cmd(K_DES, '0, '1, 1'b0);
            tick();
            lo = ilv ? (base[1:0] ^ 2'(i)) : (base[1:0] + 2'(i));
            a = {base[AW-1:2], lo};
            chk(req, dout, ref_mem[a]);
        end
        tick();
    endtask

    task automatic t_burst();
        logic [DW-1:0] d [4];
        d[0] = 36'h100000001;
        d[1] = 36'h200000002;
        d[2] = 36'h300000003;
        d[3] = 36'h400000004;
        interleave = 1'b0;
        cmd(K_WR, 6'h21, 4'b0000, 1'b0);
        tick();
        cmd(K_DES, '0, 4'b0000, 1'b1);
        tick();
        din = d[0];
        tick();
        din = d[1];
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        din = d[2];
        tick();
        din = d[3];
        tick();
        for (int i = 0; i < 4; i++) ref_mem[{4'h8, 2'(1 + i)}] = d[i];
        read_one(6'h20, "R7 linear write wrap");
        burst_read(6'h23, 1'b0, "R7 linear read wrap");
        burst_read(6'h22, 1'b1, "R7 interleaved read");
        interleave = 1'b0;
    endtask

    task automatic t_cont_desel();
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        cmd(K_WR, 6'd20, 4'b0000, 1'b1);
        din = 36'h777777777;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_bit("R8 continue deselect", dout_en, 1'b0);
        end
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        tick();
        read_one(6'd20, "R8 no write on continue deselect");
    endtask

    task automatic t_sleep();
        sleep = 1'b1;
        cmd(K_WR, 6'd42, 4'b0000, 1'b0);
        tick();
        cmd(K_WR, 6'd43, 4'b0000, 1'b0);
        tick();
        cmd(K_WR, 6'd44, 4'b0000, 1'b0);
        din = 36'h042042042;
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        din = 36'h043043043;
        tick();
        ref_mem[42] = 36'h042042042;
        ref_mem[43] = 36'h043043043;
        din = 36'h999999999;
        tick();
        chk_bit("R9 asleep hi-z", dout_en, 1'b0);
        sleep = 1'b0;
        cmd(K_WR, 6'd41, 4'b0000, 1'b0);
        tick();
        tick();
        cmd(K_RD, 6'd3, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        chk_bit("R9 sampled after wake", dout_en, 1'b1);
        chk("R9 sampled after wake", dout, ref_mem[3]);
        tick();
        tick();
        read_one(6'd42, "R9 write before sleep edge");
        read_one(6'd43, "R9 write one edge after sleep");
        read_one(6'd44, "R9 write ignored asleep");
        read_one(6'd41, "R9 write ignored during wake");
    endtask

    task automatic t_output_enable();
        oe_n = 1'b1;
        cmd(K_RD, 6'd3, '1, 1'b0);
        tick();
        cmd(K_DES, '0, '1, 1'b0);
        tick();
        chk_bit("R10 oe high hi-z", dout_en, 1'b0);
        oe_n = 1'b0;
        #1;
        chk_bit("R10 oe low drives at once", dout_en, 1'b1);
        oe_n = 1'b1;
        #1;
        chk_bit("R10 oe high at once", dout_en, 1'b0);
        oe_n = 1'b0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        cmd(K_DES, '0, '1, 1'b0);
        cke_n = 1'b0;
        oe_n = 1'b0;
        sleep = 1'b0;
        interleave = 1'b0;
        din = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latency();
        t_bytes();
        t_back_to_back();
        t_chip_select();
        t_freeze();
        t_burst();
        t_cont_desel();
        t_sleep();
        t_output_enable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule